// File: doc/BRIEF.md
# Windowed Keyed Watchdog Timer

This block watches for regular software service writes and flags the runaway case. Each service is a byte written to a service register. It must land inside a time window measured in slow timer ticks, and it must carry a fixed key. The window has a lower bound, so a service that comes too soon is an error. It also has an upper bound, so a service that never comes is an error.

The first service after reset does two jobs. It chooses the upper bound and it chooses whether the clock monitor is on. From then on those options are locked. Every later service must repeat the stored options together with the key.

Counting stops while the processor is halted or idle. Leaving either mode counts as a hardware service and restarts the lower-window interval.

A small clock monitor runs alongside the watchdog. It raises an error when the tick input stops toggling for too long. It keeps running during halt and idle.

The service byte is laid out as follows: bits [7:6] select the window, bit [5] enables the monitor, and bits [4:0] hold the key. The controller is a five-state machine:

- `ST_FIRST` waits for the initial service. Its upper bound is fixed at the largest window, and it has no lower bound.
- `ST_LOW` is the lower-window interval, in which any service is early.
- `ST_OPEN` is the interval in which a service is accepted.
- `ST_SUSP` is entered whenever halt or idle is high.
- `ST_ERR` lasts one cycle and drives the error pulse.

The transitions are:

- `ST_FIRST` goes to `ST_LOW` on a good key.
- `ST_FIRST` goes to `ST_ERR` on a bad key or on reaching the deadline.
- `ST_LOW` goes to `ST_OPEN` once the lower count is reached.
- `ST_LOW` and `ST_OPEN` go to `ST_LOW` on a matching service.
- `ST_LOW` and `ST_OPEN` go to `ST_ERR` on an early, mismatched or missing service.
- Any counting state goes to `ST_SUSP` on halt or idle.
- `ST_SUSP` goes to `ST_FIRST` if it was entered before the options were locked, and to `ST_LOW` otherwise.
- `ST_ERR` goes to `ST_FIRST` if the options are still unlocked, and to `ST_LOW` otherwise.

Top module: `wdt_guard`

## Requirements
- R1: After reset, rd_data reads 8'hE0 (window select 2'b11, monitor enabled), wd_err and cm_err are low, and the first service deadline is 8×WIN_UNIT ticks (65,536 with default parameters).
- R2: The first service must carry key 5'b01100 in bits [4:0]. With that key it is accepted, even when fewer than LOW_TICKS ticks have passed. With any other key it causes one wd_err pulse, and the options keep their reset values.
- R3: The first accepted service loads the window select from bits [7:6] and the monitor enable from bit [5]. No later write changes them.
- R4: A later service is accepted only if the whole byte equals {window select, monitor enable, 5'b01100}. Anything else raises wd_err. An accepted service restarts the tick count from zero.
- R5: rd_data always returns {window select, monitor enable, 5'b00000}, so the key field never reads back.
- R6: A later service that arrives when fewer than LOW_TICKS ticks have been counted since the last restart raises wd_err.
- R7: A wd_err pulse is raised on the tick that completes the upper bound without a service. The upper bound is WIN_UNIT ticks for select 00, 2× for 01, 4× for 10 and 8× for 11.
- R8: wd_err is high for exactly one clock. After it, the tick count restarts from zero, and once the options are locked the lower window applies again.
- R9: While halt or idle is high, ticks are not counted, service writes are ignored, and no wd_err is raised.
- R10: Leaving halt or idle restarts the tick count from zero. After the options are locked, this also restarts the lower-window interval, so a service right after the exit is early.
- R11: When the monitor is enabled and tick stays low for STUCK_LIMIT clocks, cm_err goes high and stays high until tick returns. This happens during halt and idle as well. When the monitor is disabled, cm_err stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow timer tick, one clock wide per count |
| halt | input | 1 | Processor halted |
| idle | input | 1 | Processor idle |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service byte: [7:6] window, [5] monitor enable, [4:0] key |
| rd_data | output | 8 | Service register read-back, key field as zeros |
| wd_err | output | 1 | Watchdog error, one-clock pulse |
| cm_err | output | 1 | Clock monitor error, level |

## Verification
A corrupted state register or a stale lower-window flag shows up at wd_err quickly. A pulse fires one clock after a service that should have passed, or no pulse fires after an early service. A counter that fails to restart moves the deadline pulse by a whole window, so it is seen within one upper-bound period. A broken option lock shows up at rd_data right after the next service. A clock monitor fault shows up at cm_err within STUCK_LIMIT clocks of tick stopping.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        ST_FIRST,
        ST_LOW,
        ST_OPEN,
        ST_SUSP,
        ST_ERR
    } wdt_state_e;

    localparam logic [4:0] SVC_KEY = 5'b01100;

    typedef struct packed {
        logic [1:0] win;
        logic       mon;
        logic [4:0] key;
    } svc_word_t;

endpackage

// File: rtl/wdt_tick_ctr.sv
module wdt_tick_ctr #(
    parameter int LOW_TICKS = 2048,
    parameter int WIN_UNIT  = 8192,
    parameter int CW        = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cnt_en,
    input  logic          first_phase,
    input  logic [1:0]    win_sel,
    output logic [CW-1:0] cnt,
    output logic          early,
    output logic          deadline
);
    logic [CW-1:0] bound_tab [4];
    logic [CW-1:0] bound;

    for (genvar g = 0; g < 4; g++) begin : g_bound
        assign bound_tab[g] = CW'(WIN_UNIT << g);
    end

    assign bound    = first_phase ? bound_tab[3] : bound_tab[win_sel];
    assign early    = cnt < CW'(LOW_TICKS);
    assign deadline = cnt_en && (cnt == bound - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (cnt_en) cnt <= cnt + CW'(1);
    end

    assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= bound_tab[3]);

endmodule

// File: rtl/wdt_key_cmp.sv
module wdt_key_cmp
    import wdt_pkg::*;
(
    input  logic [7:0] wr_data,
    input  logic [1:0] win_q,
    input  logic       mon_q,
    output logic       key_ok,
    output logic       all_ok,
    output logic [7:0] rd_data
);
    svc_word_t wr_w;
    svc_word_t rd_w;

    always_comb begin
        wr_w     = svc_word_t'(wr_data);
        key_ok   = (wr_w.key == SVC_KEY);
        all_ok   = key_ok && (wr_w.win == win_q) && (wr_w.mon == mon_q);
        rd_w.win = win_q;
        rd_w.mon = mon_q;
        rd_w.key = '0;
        rd_data  = rd_w;
    end

endmodule

// File: rtl/wdt_clk_mon.sv
module wdt_clk_mon #(
    parameter int STUCK_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mon_en,
    output logic cm_err
);
    localparam int SW = $clog2(STUCK_LIMIT + 1);

    logic [SW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                          idle_cnt <= '0;
        else if (tick)                       idle_cnt <= '0;
        else if (idle_cnt != SW'(STUCK_LIMIT)) idle_cnt <= idle_cnt + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cm_err <= 1'b0;
        else        cm_err <= mon_en && !tick && (idle_cnt == SW'(STUCK_LIMIT));
    end

    assert_mon_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !cm_err);

    assert_tick_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !cm_err);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int LOW_TICKS   = 2048,
    parameter int WIN_UNIT    = 8192,
    parameter int STUCK_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       halt,
    input  logic       idle,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       wd_err,
    output logic       cm_err
);
    localparam int CW = $clog2(WIN_UNIT * 8 + 1);

    wdt_state_e    state_q, state_d;
    logic          from_first_q;
    logic          locked_q;
    logic [1:0]    win_q;
    logic          mon_q;
    logic          susp;
    logic          clr;
    logic          lock_now;
    logic          cnt_en;
    logic          key_ok, all_ok, early, deadline;
    logic [CW-1:0] cnt;

    assign susp   = halt | idle;
    assign cnt_en = tick && !susp &&
                    (state_q == ST_FIRST || state_q == ST_LOW || state_q == ST_OPEN);

    wdt_tick_ctr #(.LOW_TICKS(LOW_TICKS), .WIN_UNIT(WIN_UNIT), .CW(CW)) ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en),
        .first_phase(!locked_q), .win_sel(win_q),
        .cnt(cnt), .early(early), .deadline(deadline)
    );

    wdt_key_cmp cmp_i (
        .wr_data(wr_data), .win_q(win_q), .mon_q(mon_q),
        .key_ok(key_ok), .all_ok(all_ok), .rd_data(rd_data)
    );

    wdt_clk_mon #(.STUCK_LIMIT(STUCK_LIMIT)) mon_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mon_en(mon_q), .cm_err(cm_err)
    );

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        clr      = 1'b0;
        lock_now = 1'b0;
        unique case (state_q)
            ST_FIRST: begin
                if (susp) state_d = ST_SUSP;
                else if (wr_en) begin
                    if (key_ok) begin
                        lock_now = 1'b1;
                        clr      = 1'b1;
                        state_d  = ST_LOW;
                    end else begin
                        state_d = ST_ERR;
                    end
                end else if (deadline) state_d = ST_ERR;
            end
            ST_LOW, ST_OPEN: begin
                if (susp) state_d = ST_SUSP;
                else if (wr_en) begin
                    if (early || !all_ok) state_d = ST_ERR;
                    else begin
                        clr     = 1'b1;
                        state_d = ST_LOW;
                    end
                end else if (deadline) state_d = ST_ERR;
                else if (state_q == ST_LOW && !early) state_d = ST_OPEN;
            end
            ST_SUSP: begin
                if (!susp) begin
                    clr     = 1'b1;
                    state_d = from_first_q ? ST_FIRST : ST_LOW;
                end
            end
            ST_ERR: begin
                clr     = 1'b1;
                state_d = locked_q ? ST_LOW : ST_FIRST;
            end
            default: state_d = ST_FIRST;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_FIRST;
            from_first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_SUSP && state_q != ST_SUSP)
                from_first_q <= (state_q == ST_FIRST);
        end
    end

    // Option storage, written once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            win_q    <= 2'b11;
            mon_q    <= 1'b1;
        end else if (lock_now && !locked_q) begin
            locked_q <= 1'b1;
            win_q    <= wr_data[7:6];
            mon_q    <= wr_data[5];
        end
    end

    // Outputs
    always_comb begin
        wd_err = (state_q == ST_ERR);
    end

    assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_err |=> !wd_err);

    assert_options_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> ($stable(win_q) && $stable(mon_q)));

    assert_early_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOW || state_q == ST_OPEN) && wr_en && early && !susp) |=> wd_err);

    assert_freeze_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && susp) |=> $stable(cnt));

    assert_exit_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && !susp) |=> (cnt == '0));

endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb_top;
    localparam int LOW = 8;
    localparam int UNIT = 32;
    localparam int STUCK = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic tick_on = 1;
    logic halt = 0, idle = 0, wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic wd_err, cm_err;
    int n_chk = 0, n_fail = 0, err_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdt_guard #(.LOW_TICKS(LOW), .WIN_UNIT(UNIT), .STUCK_LIMIT(STUCK)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_on), .halt(halt), .idle(idle),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .wd_err(wd_err), .cm_err(cm_err));

    always @(negedge clk) if (wd_err) err_cnt++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; halt = 0; idle = 0; wr_en = 0; wr_data = 0; tick_on = 1;
        step(3);
        rst_n = 1;
        step(1);
    endtask

    task automatic svc(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic t_reset_state();
        int base;
        do_reset();
        check(rd_data == 8'hE0, "R1 reset rd_data", rd_data, 8'hE0);
        check(!wd_err && !cm_err, "R1 reset errors", {wd_err, cm_err}, 0);
        base = err_cnt;
        step(UNIT * 8 - 6);
        check(err_cnt == base, "R1 no error before first deadline", err_cnt - base, 0);
        step(10);
        check(err_cnt == base + 1, "R1 first deadline error R8", err_cnt - base, 1);
    endtask

    task automatic t_first_service();
        int base;
        do_reset();
        base = err_cnt;
        svc(8'h6C);                 // win 01, mon 1, key 01100, inside lower window
        step(2);
        check(err_cnt == base, "R2 early first service accepted", err_cnt - base, 0);
        check(rd_data == 8'h60, "R3 R5 options loaded, key hidden", rd_data, 8'h60);
        do_reset();
        base = err_cnt;
        svc(8'h2D);                 // wrong key
        step(2);
        check(err_cnt == base + 1, "R2 bad key error", err_cnt - base, 1);
        check(rd_data == 8'hE0, "R2 options unchanged after bad key", rd_data, 8'hE0);
    endtask

    task automatic t_later_services();
        int base;
        do_reset();
        svc(8'h2C);                 // win 00, mon 1
        base = err_cnt;
        step(LOW + 4);
        svc(8'h2C);
        step(2);
        check(err_cnt == base, "R4 matching service accepted", err_cnt - base, 0);
        step(LOW + 4);
        svc(8'hEC);                 // window field differs
        step(2);
        check(err_cnt == base + 1, "R4 mismatched service error", err_cnt - base, 1);
        check(rd_data == 8'h20, "R3 options locked", rd_data, 8'h20);
        step(LOW + 4);
        svc(8'h2C);
        step(2);
        svc(8'h2C);                 // early
        step(2);
        check(err_cnt == base + 2, "R6 early service error", err_cnt - base, 2);
    endtask

    task automatic t_upper_window();
        int base;
        do_reset();
        svc(8'h2C);                 // upper bound 32 ticks
        base = err_cnt;
        step(UNIT - 4);
        check(err_cnt == base, "R7 no error inside window", err_cnt - base, 0);
        step(8);
        check(err_cnt == base + 1, "R7 R8 missed deadline single pulse", err_cnt - base, 1);
        step(UNIT - 8);
        check(err_cnt == base + 1, "R8 counter restarted after error", err_cnt - base, 1);
        step(10);
        check(err_cnt == base + 2, "R8 second deadline", err_cnt - base, 2);
    endtask

    task automatic t_suspend();
        int base;
        do_reset();
        svc(8'h2C);
        base = err_cnt;
        step(20);
        halt = 1;
        step(100);
        svc(8'h00);                 // ignored while halted
        step(3);
        check(err_cnt == base, "R9 halt freezes and ignores writes", err_cnt - base, 0);
        halt = 0;
        step(UNIT - 6);
        check(err_cnt == base, "R10 halt exit restarts count", err_cnt - base, 0);
        do_reset();
        svc(8'h2C);
        base = err_cnt;
        step(LOW + 4);
        idle = 1;
        step(10);
        idle = 0;
        step(2);
        svc(8'h2C);
        step(2);
        check(err_cnt == base + 1, "R10 service after idle exit is early", err_cnt - base, 1);
        do_reset();
        svc(8'h2C);
        base = err_cnt;
        idle = 1;
        step(10);
        idle = 0;
        step(LOW + 4);
        svc(8'h2C);
        step(2);
        check(err_cnt == base, "R10 service after lower window ok", err_cnt - base, 0);
    endtask

    task automatic t_clock_mon();
        do_reset();
        svc(8'hEC);                 // monitor on
        halt = 1;
        tick_on = 0;
        step(STUCK + 6);
        check(cm_err == 1, "R11 stuck tick flagged in halt", cm_err, 1);
        tick_on = 1;
        step(2);
        check(cm_err == 0, "R11 cleared on tick", cm_err, 0);
        halt = 0;
        do_reset();
        svc(8'hCC);                 // monitor off
        tick_on = 0;
        step(STUCK + 6);
        check(cm_err == 0, "R11 disabled monitor quiet", cm_err, 0);
        tick_on = 1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_first_service();
        t_later_services();
        t_upper_window();
        t_suspend();
        t_clock_mon();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule